// File: doc/BRIEF.md
# Runtime-Partitioned Packed Adder

This block adds two 16-bit packed operands. A 4-bit lane configuration picks where the carry chain is cut, in steps of 4-bit groups. The usual layouts are one 16-bit lane, two 8-bit lanes or four 4-bit lanes, but any mix of cuts works. Each lane adds its slice of the two operands plus an optional increment of one at its lowest bit. The lane sum wraps to the lane width, and the bit that falls off the top of the lane is reported as that lane's carry-out.

The block is purely combinational. Each 4-bit group precomputes its result for both incoming carry values. A small control stage walks the groups, picks each group's incoming carry from either the lane increment or the group below, and routes the lane carry-outs. A datapath that reuses one adder for scalar and short-vector work drives the configuration from its decode stage.

Top module: `simd_part_add`

## Requirements
- R1: Configuration bit k (k = 0, 1, 2) cuts the carry between bit 4k+3 and bit 4k+4. With bits 2:0 all zero, sum_o is (a_i + b_i + cin_i[0]) mod 2^16 and cout_o[0] is the carry out of bit 15.
- R2: With configuration 4'b0010, bits 7:0 and bits 15:8 are two independent 8-bit lanes, using increments cin_i[0] and cin_i[2].
- R3: With configuration 4'b1111, each nibble g is an independent 4-bit lane with increment cin_i[g] and carry-out cout_o[g].
- R4: No carry crosses a cut: a lane that overflows leaves the lane above it unchanged.
- R5: A set increment bit adds one at the lowest bit of its lane. cin_i = 4'hF adds one to every active lane.
- R6: In a lane that spans several groups, only the increment bit of its lowest group is used. The other increment bits of that lane have no effect on any output.
- R7: A lane's carry-out appears on the cout_o bit of its lowest group. Every other cout_o bit is 0.
- R8: An all-ones lane plus one wraps the lane to zero and sets its carry-out. This holds whether the one comes from the b_i operand or from the increment.
- R9: Configuration bit 3 has no effect, because the top of the word is always a lane edge. Irregular layouts such as 4'b0100 (a 12-bit lane under a 4-bit lane) obey R4 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First packed operand |
| b_i | input | 16 | Second packed operand |
| cfg_i | input | 4 | Lane cuts, bit k cuts above nibble k; bit 3 ignored |
| cin_i | input | 4 | Per-group increment, used at each lane's lowest group |
| sum_o | output | 16 | Packed lane sums, each wrapped to its lane width |
| cout_o | output | 4 | Lane carry-outs at each lane's lowest group position |

## Verification
The hardest case to reach is a carry that would ripple across a cut while stray increment bits sit inside a merged lane. Only that combination shows both that the cut holds and that the ignored increments stay ignored. The stimulus pairs all-ones lane operands with a one in each lane's lowest bit, in every layout. It repeats the same data with increment masks that set only non-lowest group bits. It also flips configuration bit 3 and uses an irregular 12/4 split, so the lane-edge logic is exercised away from the symmetric layouts.

// File: rtl/simd_add_pkg.sv
`timescale 1ns/1ps
package simd_add_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned N_GRP   = 4;
  localparam int unsigned GRP_W   = DATA_W / N_GRP;
endpackage

// File: rtl/simd_grp_add.sv
`timescale 1ns/1ps
// One group: carry-select pair for incoming carry 0 and 1
module simd_grp_add #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  output logic [GW-1:0] s0_o,
  output logic          c0_o,
  output logic [GW-1:0] s1_o,
  output logic          c1_o
);
  localparam int unsigned EW = GW + 1;

  assign {c0_o, s0_o} = EW'(a_i) + EW'(b_i);
  assign {c1_o, s1_o} = EW'(a_i) + EW'(b_i) + EW'(1);

  always_comb begin
    assert_inc_R5: assert ({c1_o, s1_o} == {c0_o, s0_o} + EW'(1))
      else $error("carry-in=1 result is not carry-in=0 result plus one");
  end
endmodule

// File: rtl/simd_lane_ctl.sv
`timescale 1ns/1ps
// Picks each group's carry-in and routes lane carry-outs to lane-low bits
module simd_lane_ctl #(
  parameter int unsigned G = 4
) (
  input  logic [G-1:0] cfg_i,
  input  logic [G-1:0] cin_i,
  input  logic [G-1:0] c0_i,
  input  logic [G-1:0] c1_i,
  output logic [G-1:0] csel_o,
  output logic [G-1:0] cout_o
);
  logic [G-1:0] lane_lo;

  for (genvar g = 0; g < G; g++) begin : g_lo
    if (g == 0) begin : g_first
      assign lane_lo[g] = 1'b1;
    end else begin : g_rest
      assign lane_lo[g] = cfg_i[g-1];
    end
  end

  always_comb begin
    logic c;
    int   lo;
    c      = 1'b0;
    lo     = 0;
    csel_o = '0;
    cout_o = '0;
    for (int g = 0; g < G; g++) begin
      if (lane_lo[g]) begin
        c  = cin_i[g];
        lo = g;
      end
      csel_o[g] = c;
      c = c ? c1_i[g] : c0_i[g];
      // top group is always a lane edge, so cfg_i[G-1] changes nothing
      if (cfg_i[g] || g == G - 1) cout_o[lo] = c;
    end
  end

  always_comb begin
    for (int g = 0; g < G; g++) begin
      if (!lane_lo[g]) begin
        assert_cout_hole_R7: assert (cout_o[g] == 1'b0)
          else $error("carry-out on non-lowest group %0d", g);
      end
    end
  end
endmodule

// File: rtl/simd_part_add.sv
`timescale 1ns/1ps
module simd_part_add
  import simd_add_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned NG = N_GRP
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [NG-1:0] cfg_i,
  input  logic [NG-1:0] cin_i,
  output logic [W-1:0]  sum_o,
  output logic [NG-1:0] cout_o
);
  localparam int unsigned GW = W / NG;

  logic [NG-1:0][GW-1:0] s0, s1;
  logic [NG-1:0]         c0, c1, csel;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    simd_grp_add #(.GW(GW)) u_grp (
      .a_i  (a_i[g*GW +: GW]),
      .b_i  (b_i[g*GW +: GW]),
      .s0_o (s0[g]),
      .c0_o (c0[g]),
      .s1_o (s1[g]),
      .c1_o (c1[g])
    );
    assign sum_o[g*GW +: GW] = csel[g] ? s1[g] : s0[g];
  end

  simd_lane_ctl #(.G(NG)) u_ctl (
    .cfg_i  (cfg_i),
    .cin_i  (cin_i),
    .c0_i   (c0),
    .c1_i   (c1),
    .csel_o (csel),
    .cout_o (cout_o)
  );

  always_comb begin
    if (cfg_i[NG-2:0] == '0) begin
      assert_full_lane_R1: assert ({cout_o[0], sum_o} ==
          (W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i[0]))
        else $error("single-lane sum mismatch");
      assert_full_cout_R7: assert (cout_o[NG-1:1] == '0)
        else $error("stray carry-out in single-lane layout");
    end
    for (int g = 0; g < NG; g++) begin
      if ((g == 0 || cfg_i[(g == 0) ? 0 : g-1]) && (g == NG-1 || cfg_i[g])) begin
        assert_lane_iso_R4: assert ({cout_o[g], sum_o[g*GW +: GW]} ==
            (GW+1)'(a_i[g*GW +: GW]) + (GW+1)'(b_i[g*GW +: GW]) + (GW+1)'(cin_i[g]))
          else $error("isolated group %0d mismatch", g);
      end
    end
  end
endmodule

// File: tb/tb_simd_part_add.sv
`timescale 1ns/1ps
module tb_simd_part_add;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b, sum;
  logic [3:0]  cfg, cin, cout;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] a, b, exp_sum;
    logic [3:0]  cfg, cin, exp_cout;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  simd_part_add dut (
    .a_i(a), .b_i(b), .cfg_i(cfg), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  // lane model: mask lane, add operands and lane increment, cut at lane width
  function automatic void model(input logic [3:0] c, input logic [15:0] x, y,
                                input logic [3:0] ci,
                                output logic [15:0] s, output logic [3:0] co);
    int lo;
    logic [16:0] m, t;
    s = '0; co = '0; lo = 0;
    for (int g = 0; g < 4; g++) begin
      if (g == 0 || c[g-1]) lo = g;
      if (g == 3 || c[g]) begin
        m = ((17'd1 << ((g + 1) * 4)) - 17'd1) & ~((17'd1 << (lo * 4)) - 17'd1);
        t = ({1'b0, x} & m) + ({1'b0, y} & m) + (ci[lo] ? (17'd1 << (lo * 4)) : 17'd0);
        s = s | (t[15:0] & m[15:0]);
        co[lo] = t[(g + 1) * 4];
      end
    end
  endfunction

  task automatic drive(input logic [3:0] c, input logic [15:0] x, y,
                       input logic [3:0] ci, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    cfg = c; a = x; b = y; cin = ci;
    it.a = x; it.b = y; it.cfg = c; it.cin = ci; it.tag = tag;
    model(c, x, y, ci, it.exp_sum, it.exp_cout);
    sb_q.push_back(it);
  endtask

  // monitor samples on the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (sum !== it.exp_sum || cout !== it.exp_cout) begin
        n_fail++;
        $display("FAIL %s: cfg=%b a=%h b=%h cin=%b sum=%h exp=%h cout=%b exp=%b",
                 it.tag, it.cfg, it.a, it.b, it.cin, sum, it.exp_sum, cout, it.exp_cout);
      end
    end
  end

  initial begin
    a = '0; b = '0; cfg = '0; cin = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    wait (rst_ni);
    drive(4'b0000, 16'h0000, 16'h0000, 4'h0, "R1 idle");
    drive(4'b0000, 16'h1234, 16'h4321, 4'h1, "R1");
    drive(4'b0000, 16'h0FFF, 16'h0001, 4'h0, "R1 ripple");
    drive(4'b0010, 16'h12F0, 16'h0110, 4'h0, "R2");
    drive(4'b0010, 16'h7F80, 16'h0180, 4'h5, "R2");
    drive(4'b1111, 16'h1234, 16'h8765, 4'h0, "R3");
    drive(4'b1111, 16'h9ABC, 16'h7777, 4'hA, "R3");
    drive(4'b0010, 16'h00FF, 16'h0001, 4'h0, "R4");
    drive(4'b1111, 16'h0F0F, 16'h0101, 4'h0, "R4");
    drive(4'b0000, 16'h0000, 16'h0000, 4'hF, "R5");
    drive(4'b0010, 16'h0000, 16'h0000, 4'hF, "R5");
    drive(4'b1111, 16'h0000, 16'h0000, 4'hF, "R5");
    drive(4'b0000, 16'h0000, 16'h0000, 4'hE, "R6");
    drive(4'b0010, 16'h0000, 16'h0000, 4'hA, "R6");
    drive(4'b0010, 16'h00FF, 16'h0000, 4'hA, "R6");
    drive(4'b0010, 16'hFF00, 16'h0100, 4'h0, "R7");
    drive(4'b0000, 16'hFFFF, 16'h0001, 4'h0, "R7");
    drive(4'b0100, 16'hFFFF, 16'h1001, 4'h0, "R7");
    drive(4'b0000, 16'hFFFF, 16'h0001, 4'h0, "R8");
    drive(4'b0010, 16'hFFFF, 16'h0101, 4'h0, "R8");
    drive(4'b1111, 16'hFFFF, 16'h1111, 4'h0, "R8");
    drive(4'b1111, 16'hFFFF, 16'h0000, 4'hF, "R8");
    drive(4'b1010, 16'hFFFF, 16'h0101, 4'h0, "R9");
    drive(4'b0111, 16'hFFFF, 16'h1111, 4'h0, "R9");
    drive(4'b1000, 16'hFFFF, 16'h0001, 4'hE, "R9");
    drive(4'b0100, 16'h0FFF, 16'hF001, 4'h9, "R9");
    for (int i = 0; i < 120; i++) begin
      logic [3:0] c;
      c = (i % 3 == 0) ? 4'b0000 : (i % 3 == 1) ? 4'b0010 : 4'b1111;
      drive(c, 16'($urandom), 16'($urandom), 4'($urandom), "R3 rand");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule